// File: doc/BRIEF.md
# Interrupt Command Register Front End

This block decodes register accesses for the command, identity and logical-destination registers of a local interrupt controller. It has two access ports. The memory-mapped port carries 32-bit data, and its register index is address bits 11:4. The extended port carries 64-bit data and names the register index directly. A write to the command register is split into its delivery fields and becomes an inter-processor interrupt (IPI) request to a downstream destination resolver. The request is held until that resolver accepts it.

The register rules change with the operating mode. In the legacy (8-bit ID) mode, the destination comes from the upper byte of the command-high register. In the extended (32-bit ID) mode, one 64-bit command write carries both the destination and the fields. In that mode a self-IPI register is also available, and the identity and logical-destination registers become read-only or hidden. A memory-mapped write to index 0, or to any address above 0xFFF, is not a register access. It is decoded as a message-signalled interrupt and passed to a separate output.

Top module: `icr_front`

## Requirements
- R1: A write to the command-low register (index 0x30) issues an IPI with these fields: vector = data bits 7:0, delivery mode = bits 10:8, destination mode = bit 11, trigger = bit 15, shorthand = bits 19:18. A read of index 0x30 returns the last value written there.
- R2: In legacy mode, a write to command-high (index 0x31) stores all 32 bits. The IPI destination is bits 31:24 of command-high, zero-extended.
- R3: In extended mode, a 64-bit command-low write uses data bits 63:32 as the IPI destination and also stores them as command-high. A later read of index 0x31 returns them.
- R4: In extended mode, writes to ID (0x02), logical destination (0x0D), destination format (0x0E) and command-high (0x31) answer with an error and change no state.
- R5: A write to the self-IPI register (index 0x3F) in extended mode issues an IPI with the vector from data bits 7:0, shorthand 1 (self), delivery 0, destination mode 0, trigger 0 and destination 0. In legacy mode the same write answers with an error and issues nothing.
- R6: An ID read returns the 32-bit initial ID in extended mode, and the stored 8-bit ID shifted left by 24 in legacy mode. A logical-destination read returns {initial ID bits 19:4, one-hot of initial ID bits 3:0} in extended mode, and the stored byte shifted left by 24 in legacy mode. After reset the stored ID is initial ID bits 7:0 and the logical byte is 0.
- R7: A destination-format read returns 0 with an error in extended mode. In legacy mode it returns the 4-bit model in bits 31:28 and ones in bits 27:0; the model resets to 0xF.
- R8: Any access on the extended port while in legacy mode answers with an error, returns 0 and has no effect.
- R9: An access to an index outside {0x02, 0x0D, 0x0E, 0x30, 0x31, 0x3F}, or a read of 0x3F, answers with an error and sets a sticky illegal-address flag that only reset clears.
- R10: A memory-mapped access with a size below 4 bytes has no effect, returns 0 and answers without error.
- R11: A memory-mapped write of 4 or more bytes to index 0, or to an address above 0xFFF, produces a one-cycle message pulse and no register access. The pulse carries: destination = address bits 63:32 ORed with address bits 19:12, destination mode = address bit 2, vector = data bits 7:0, delivery = bits 10:8, trigger = bit 15.
- R12: An issued IPI stays valid with stable fields until it is accepted. While it is pending, the ready output is low and requests on both ports are ignored. When both ports request in the same cycle, the memory-mapped port is served and the extended request is ignored.
- R13: Every accepted access produces exactly one response strobe, one cycle after the edge that accepts it. IPI and message outputs rise on that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 1 = extended (32-bit ID) mode |
| init_id | input | 32 | Initial controller ID |
| mm_req | input | 1 | Memory-mapped access request |
| mm_we | input | 1 | Memory-mapped write |
| mm_addr | input | ADDR_W | Memory-mapped byte address |
| mm_size | input | 4 | Access size in bytes |
| mm_wdata | input | 32 | Memory-mapped write data |
| xr_req | input | 1 | Extended-port access request |
| xr_we | input | 1 | Extended-port write |
| xr_idx | input | 8 | Extended-port register index |
| xr_wdata | input | 64 | Extended-port write data |
| acc_ready | output | 1 | Requests are taken this cycle |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Access refused |
| rsp_data | output | 64 | Read data |
| esr_illegal | output | 1 | Sticky illegal-address flag |
| ipi_valid | output | 1 | IPI request pending |
| ipi_ready | input | 1 | Resolver accepts the IPI |
| ipi_vector | output | 8 | IPI vector |
| ipi_dlv | output | 3 | IPI delivery mode |
| ipi_dst_mode | output | 1 | IPI destination mode |
| ipi_trig | output | 1 | IPI trigger mode |
| ipi_shorthand | output | 2 | IPI destination shorthand |
| ipi_dest | output | 32 | IPI destination |
| msi_valid | output | 1 | Message interrupt pulse |
| msi_dest | output | 32 | Message destination |
| msi_vector | output | 8 | Message vector |
| msi_dlv | output | 3 | Message delivery mode |
| msi_dst_mode | output | 1 | Message destination mode |
| msi_trig | output | 1 | Message trigger |

## Verification
Every result of an accepted access is due one clock after the accepting edge: the response strobe with its data and error flag, a newly issued IPI, and a message pulse. The pulses fall after one more edge. An IPI held by a low ready falls one edge after ready is seen high. The bench predicts every output for each cycle from a behavioural model that it updates just after each rising edge. It compares all outputs on the following falling edge, so each value is checked in the exact cycle it is due and in the cycles before and after.

// File: rtl/icr_pkg.sv
package icr_pkg;
   localparam int IDX_W   = 8;
   localparam int ID_W    = 32;
   localparam int VEC_W   = 8;
   localparam int XDATA_W = 64;
   localparam int MDATA_W = 32;

   localparam logic [IDX_W-1:0] IX_ID     = 8'h02;
   localparam logic [IDX_W-1:0] IX_LDR    = 8'h0D;
   localparam logic [IDX_W-1:0] IX_DFR    = 8'h0E;
   localparam logic [IDX_W-1:0] IX_CMD_LO = 8'h30;
   localparam logic [IDX_W-1:0] IX_CMD_HI = 8'h31;
   localparam logic [IDX_W-1:0] IX_SELF   = 8'h3F;

   localparam logic [1:0] SH_SELF = 2'd1;

   typedef struct packed {
      logic [ID_W-1:0]  dest;
      logic [1:0]       shorthand;
      logic             trig;
      logic             dst_mode;
      logic [2:0]       dlv;
      logic [VEC_W-1:0] vec;
   } ipi_t;
endpackage

// File: rtl/icr_decode.sv
module icr_decode
   import icr_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int MSI_WIDE = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_ready,
   input  logic                 ext_mode,
   input  logic                 mm_req,
   input  logic                 mm_we,
   input  logic [ADDR_W-1:0]    mm_addr,
   input  logic [3:0]           mm_size,
   input  logic [MDATA_W-1:0]   mm_wdata,
   input  logic                 xr_req,
   input  logic                 xr_we,
   input  logic [IDX_W-1:0]     xr_idx,
   input  logic [XDATA_W-1:0]   xr_wdata,
   output logic                 go,
   output logic                 we,
   output logic [IDX_W-1:0]     idx,
   output logic [XDATA_W-1:0]   wdata,
   output logic                 narrow,
   output logic                 divert,
   output logic                 xdeny,
   output logic                 msi_valid,
   output logic [ID_W-1:0]      msi_dest,
   output logic [VEC_W-1:0]     msi_vector,
   output logic [2:0]           msi_dlv,
   output logic                 msi_dst_mode,
   output logic                 msi_trig
);
   localparam int IDX_LSB = 4;
   localparam int PAGE_W  = IDX_LSB + IDX_W;

   if (ADDR_W < PAGE_W + 1) begin : g_addr_chk
      $error("icr_decode: ADDR_W too small");
   end
   if (MSI_WIDE != 0 && (ADDR_W <= ID_W || ADDR_W > 2 * ID_W)) begin : g_wide_chk
      $error("icr_decode: MSI_WIDE needs ADDR_W in 33..64");
   end

   logic mm_go, xr_go, high_addr;
   logic [ID_W-1:0] upper_id;
   logic unused_addr_bits;

   assign unused_addr_bits = ^{mm_addr[3], mm_addr[1:0]};

   assign mm_go     = mm_req & acc_ready;
   assign xr_go     = xr_req & acc_ready & ~mm_req;
   assign go        = mm_go | xr_go;
   assign we        = mm_go ? mm_we : xr_we;
   assign idx       = mm_go ? mm_addr[PAGE_W-1:IDX_LSB] : xr_idx;
   assign wdata     = mm_go ? {{(XDATA_W-MDATA_W){1'b0}}, mm_wdata} : xr_wdata;
   assign high_addr = |mm_addr[ADDR_W-1:PAGE_W];
   assign narrow    = mm_go & (mm_size < 4'd4);
   assign divert    = mm_go & mm_we & ~narrow &
                      (high_addr | (mm_addr[PAGE_W-1:IDX_LSB] == '0));
   assign xdeny     = xr_go & ~ext_mode;

   if (MSI_WIDE != 0) begin : g_wide
      assign upper_id = ID_W'(mm_addr[ADDR_W-1:ID_W]);
   end else begin : g_narrow
      assign upper_id = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msi_valid    <= 1'b0;
         msi_dest     <= '0;
         msi_vector   <= '0;
         msi_dlv      <= '0;
         msi_dst_mode <= 1'b0;
         msi_trig     <= 1'b0;
      end else begin
         msi_valid <= divert;
         if (divert) begin
            msi_dest     <= upper_id | {{(ID_W-8){1'b0}}, mm_addr[19:12]};
            msi_dst_mode <= mm_addr[2];
            msi_vector   <= mm_wdata[VEC_W-1:0];
            msi_dlv      <= mm_wdata[10:8];
            msi_trig     <= mm_wdata[15];
         end
      end
   end

   // R11
   msi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      divert |=> msi_valid);

   // R12
   blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_ready |-> !go);
endmodule

// File: rtl/icr_regs.sv
module icr_regs
   import icr_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic               we,
   input  logic               narrow,
   input  logic               divert,
   input  logic               xdeny,
   input  logic               ext_mode,
   input  logic [IDX_W-1:0]   idx,
   input  logic [XDATA_W-1:0] wdata,
   input  logic [ID_W-1:0]    init_id,
   output logic               rsp_valid,
   output logic               rsp_err,
   output logic [XDATA_W-1:0] rsp_data,
   output logic               esr_illegal,
   output logic               issue,
   output ipi_t               issue_pkt
);
   logic eff, known, illegal, locked, self_leg, dfr_hide, err_now, wr_ok;
   logic issue_cmd, issue_self;
   logic [7:0]      id_q, ldr_q;
   logic [3:0]      model_q;
   logic [31:0]     lo_q, hi_q, rd;
   logic [ID_W-1:0] xldr;
   logic [15:0]     one_hot;

   assign one_hot = 16'h1 << init_id[3:0];
   assign xldr    = {init_id[19:4], one_hot};

   always_comb begin
      known    = idx inside {IX_ID, IX_LDR, IX_DFR, IX_CMD_LO, IX_CMD_HI, IX_SELF};
      eff      = go & ~narrow & ~divert & ~xdeny;
      illegal  = eff & (~known | (~we & (idx == IX_SELF)));
      locked   = eff & we & ext_mode &
                 (idx inside {IX_ID, IX_LDR, IX_DFR, IX_CMD_HI});
      self_leg = eff & we & ~ext_mode & (idx == IX_SELF);
      dfr_hide = eff & ~we & ext_mode & (idx == IX_DFR);
      err_now  = xdeny | illegal | locked | self_leg | dfr_hide;
      wr_ok    = eff & we & known & ~locked & ~self_leg;
   end

   always_comb begin
      rd = '0;
      case (idx)
         IX_ID:     rd = ext_mode ? init_id : {id_q, 24'h0};
         IX_LDR:    rd = ext_mode ? xldr : {ldr_q, 24'h0};
         IX_DFR:    rd = ext_mode ? 32'h0 : {model_q, 28'hFFF_FFFF};
         IX_CMD_LO: rd = lo_q;
         IX_CMD_HI: rd = hi_q;
         default:   rd = '0;
      endcase
   end

   assign issue_cmd = wr_ok & (idx == IX_CMD_LO);
   assign issue_self = wr_ok & (idx == IX_SELF);
   assign issue = issue_cmd | issue_self;

   always_comb begin
      issue_pkt = '0;
      issue_pkt.vec = wdata[VEC_W-1:0];
      if (issue_cmd) begin
         issue_pkt.dlv       = wdata[10:8];
         issue_pkt.dst_mode  = wdata[11];
         issue_pkt.trig      = wdata[15];
         issue_pkt.shorthand = wdata[19:18];
         issue_pkt.dest      = ext_mode ? wdata[63:32] : {24'h0, hi_q[31:24]};
      end else begin
         issue_pkt.shorthand = SH_SELF;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_q        <= init_id[7:0];
         ldr_q       <= '0;
         model_q     <= 4'hF;
         lo_q        <= '0;
         hi_q        <= '0;
         esr_illegal <= 1'b0;
         rsp_valid   <= 1'b0;
         rsp_err     <= 1'b0;
         rsp_data    <= '0;
      end else begin
         rsp_valid <= go;
         rsp_err   <= go & err_now;
         rsp_data  <= (eff & ~we & ~err_now) ? {32'h0, rd} : '0;
         if (illegal) esr_illegal <= 1'b1;
         if (wr_ok) begin
            case (idx)
               IX_ID:     id_q    <= wdata[31:24];
               IX_LDR:    ldr_q   <= wdata[31:24];
               IX_DFR:    model_q <= wdata[31:28];
               IX_CMD_HI: hi_q    <= wdata[31:0];
               IX_CMD_LO: begin
                  lo_q <= wdata[31:0];
                  if (ext_mode) hi_q <= wdata[63:32];
               end
               default: ;
            endcase
         end
      end
   end

   // R13
   rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> rsp_valid);

   // R4
   id_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go & we & ext_mode & (idx == IX_ID)) |=> $stable(id_q));

   // R9
   esr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      esr_illegal |=> esr_illegal);

   // R5
   self_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go & we & ~ext_mode & ~narrow & ~divert & (idx == IX_SELF)) |=> rsp_err);
endmodule

// File: rtl/icr_ipi_hold.sv
module icr_ipi_hold
   import icr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  ipi_t pkt_in,
   input  logic ready,
   output logic valid,
   output ipi_t pkt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         pkt   <= '0;
      end else if (load) begin
         valid <= 1'b1;
         pkt   <= pkt_in;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end

   // R12
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid & ~ready) |=> (valid & $stable(pkt)));

   // R12
   load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !valid);
endmodule

// File: rtl/icr_front.sv
module icr_front
   import icr_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int MSI_WIDE = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ext_mode,
   input  logic [31:0]         init_id,
   input  logic                mm_req,
   input  logic                mm_we,
   input  logic [ADDR_W-1:0]   mm_addr,
   input  logic [3:0]          mm_size,
   input  logic [31:0]         mm_wdata,
   input  logic                xr_req,
   input  logic                xr_we,
   input  logic [7:0]          xr_idx,
   input  logic [63:0]         xr_wdata,
   output logic                acc_ready,
   output logic                rsp_valid,
   output logic                rsp_err,
   output logic [63:0]         rsp_data,
   output logic                esr_illegal,
   output logic                ipi_valid,
   input  logic                ipi_ready,
   output logic [7:0]          ipi_vector,
   output logic [2:0]          ipi_dlv,
   output logic                ipi_dst_mode,
   output logic                ipi_trig,
   output logic [1:0]          ipi_shorthand,
   output logic [31:0]         ipi_dest,
   output logic                msi_valid,
   output logic [31:0]         msi_dest,
   output logic [7:0]          msi_vector,
   output logic [2:0]          msi_dlv,
   output logic                msi_dst_mode,
   output logic                msi_trig
);
   logic go, we, narrow, divert, xdeny, issue;
   logic [IDX_W-1:0]   idx;
   logic [XDATA_W-1:0] wdata;
   ipi_t issue_pkt, held;

   assign acc_ready = ~ipi_valid;

   icr_decode #(.ADDR_W(ADDR_W), .MSI_WIDE(MSI_WIDE)) u_dec (
      .clk(clk), .rst_n(rst_n), .acc_ready(acc_ready), .ext_mode(ext_mode),
      .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr), .mm_size(mm_size),
      .mm_wdata(mm_wdata), .xr_req(xr_req), .xr_we(xr_we), .xr_idx(xr_idx),
      .xr_wdata(xr_wdata), .go(go), .we(we), .idx(idx), .wdata(wdata),
      .narrow(narrow), .divert(divert), .xdeny(xdeny),
      .msi_valid(msi_valid), .msi_dest(msi_dest), .msi_vector(msi_vector),
      .msi_dlv(msi_dlv), .msi_dst_mode(msi_dst_mode), .msi_trig(msi_trig));

   icr_regs u_regs (
      .clk(clk), .rst_n(rst_n), .go(go), .we(we), .narrow(narrow),
      .divert(divert), .xdeny(xdeny), .ext_mode(ext_mode), .idx(idx),
      .wdata(wdata), .init_id(init_id), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_data(rsp_data), .esr_illegal(esr_illegal),
      .issue(issue), .issue_pkt(issue_pkt));

   icr_ipi_hold u_hold (
      .clk(clk), .rst_n(rst_n), .load(issue), .pkt_in(issue_pkt),
      .ready(ipi_ready), .valid(ipi_valid), .pkt(held));

   assign ipi_vector    = held.vec;
   assign ipi_dlv       = held.dlv;
   assign ipi_dst_mode  = held.dst_mode;
   assign ipi_trig      = held.trig;
   assign ipi_shorthand = held.shorthand;
   assign ipi_dest      = held.dest;
endmodule

// File: tb/sim_icr_front.sv
module sim_icr_front;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_mode = 1'b0;
   logic [31:0] init_id = 32'h0001_2345;
   logic mm_req = 1'b0, mm_we = 1'b0;
   logic [63:0] mm_addr = '0;
   logic [3:0] mm_size = 4'd4;
   logic [31:0] mm_wdata = '0;
   logic xr_req = 1'b0, xr_we = 1'b0;
   logic [7:0] xr_idx = '0;
   logic [63:0] xr_wdata = '0;
   logic ipi_ready = 1'b1;
   logic acc_ready, rsp_valid, rsp_err, esr_illegal, ipi_valid;
   logic [63:0] rsp_data;
   logic [7:0] ipi_vector, msi_vector;
   logic [2:0] ipi_dlv, msi_dlv;
   logic ipi_dst_mode, ipi_trig, msi_valid, msi_dst_mode, msi_trig;
   logic [1:0] ipi_shorthand;
   logic [31:0] ipi_dest, msi_dest;

   icr_front u0 (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_err = 0;
   bit run_chk = 0;
   string tag = "R13";

   // model state
   logic [7:0] m_id = 8'h45, m_ldr = 8'h00;
   logic [3:0] m_model = 4'hF;
   logic [31:0] m_lo = '0, m_hi = '0;
   // expected outputs
   logic e_rsp_v = 0, e_err = 0, e_esr = 0, e_ipi_v = 0, e_msi_v = 0;
   logic [63:0] e_data = '0;
   logic [7:0] e_vec = 0, e_mvec = 0;
   logic [2:0] e_dlv = 0, e_mdlv = 0;
   logic e_dm = 0, e_trig = 0, e_mdm = 0, e_mtrig = 0;
   logic [1:0] e_sh = 0;
   logic [31:0] e_dest = 0, e_mdest = 0;

   task automatic chk(input string t, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", t, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (run_chk) begin
         chk("R12 acc_ready", 64'(acc_ready), 64'(!e_ipi_v));
         chk("R13 rsp_valid", 64'(rsp_valid), 64'(e_rsp_v));
         chk("R9 esr_illegal", 64'(esr_illegal), 64'(e_esr));
         chk({tag, " ipi_valid"}, 64'(ipi_valid), 64'(e_ipi_v));
         chk({tag, " msi_valid"}, 64'(msi_valid), 64'(e_msi_v));
         if (e_rsp_v) begin
            chk({tag, " rsp_err"}, 64'(rsp_err), 64'(e_err));
            chk({tag, " rsp_data"}, rsp_data, e_data);
         end
         if (e_ipi_v) begin
            chk({tag, " ipi fields"},
                {ipi_dest, 14'h0, ipi_shorthand, ipi_trig, ipi_dst_mode, ipi_dlv, ipi_vector},
                {e_dest, 14'h0, e_sh, e_trig, e_dm, e_dlv, e_vec});
         end
         if (e_msi_v) begin
            chk({tag, " msi fields"},
                {msi_dest, 18'h0, msi_trig, msi_dst_mode, msi_dlv, msi_vector},
                {e_mdest, 18'h0, e_mtrig, e_mdm, e_mdlv, e_mvec});
         end
      end
   end

   // behavioural prediction of one accepted register access
   task automatic predict(input bit is_mm, input bit we, input logic [7:0] ix,
                          input logic [63:0] wd);
      logic [31:0] xl;
      xl = {init_id[19:4], 16'(1) << init_id[3:0]};
      if (!is_mm && !ext_mode) begin e_err = 1; return; end
      if (we) begin
         case (ix)
            8'h02: if (ext_mode) e_err = 1; else m_id = wd[31:24];
            8'h0D: if (ext_mode) e_err = 1; else m_ldr = wd[31:24];
            8'h0E: if (ext_mode) e_err = 1; else m_model = wd[31:28];
            8'h31: if (ext_mode) e_err = 1; else m_hi = wd[31:0];
            8'h30: begin
               e_ipi_v = 1; e_vec = wd[7:0]; e_dlv = wd[10:8]; e_dm = wd[11];
               e_trig = wd[15]; e_sh = wd[19:18];
               e_dest = ext_mode ? wd[63:32] : {24'h0, m_hi[31:24]};
               m_lo = wd[31:0];
               if (ext_mode) m_hi = wd[63:32];
            end
            8'h3F: if (!ext_mode) e_err = 1;
                   else begin
                      e_ipi_v = 1; e_vec = wd[7:0]; e_dlv = 0; e_dm = 0;
                      e_trig = 0; e_sh = 2'd1; e_dest = 0;
                   end
            default: begin e_err = 1; e_esr = 1; end
         endcase
      end else begin
         case (ix)
            8'h02: e_data = ext_mode ? {32'h0, init_id} : {32'h0, m_id, 24'h0};
            8'h0D: e_data = ext_mode ? {32'h0, xl} : {32'h0, m_ldr, 24'h0};
            8'h0E: if (ext_mode) e_err = 1; else e_data = {32'h0, m_model, 28'hFFF_FFFF};
            8'h30: e_data = {32'h0, m_lo};
            8'h31: e_data = {32'h0, m_hi};
            default: begin e_err = 1; e_esr = 1; end
         endcase
      end
   endtask

   task automatic acc(input string t, input bit is_mm, input bit we,
                      input logic [63:0] a, input logic [3:0] sz, input logic [63:0] wd);
      @(negedge clk);
      tag = t;
      if (is_mm) begin
         mm_req = 1; mm_we = we; mm_addr = a; mm_size = sz; mm_wdata = wd[31:0];
      end else begin
         xr_req = 1; xr_we = we; xr_idx = a[7:0]; xr_wdata = wd;
      end
      @(posedge clk); #1;
      e_rsp_v = 1; e_err = 0; e_data = 0;
      if (is_mm && sz < 4) begin
      end else if (is_mm && we && (a > 64'hFFF || a[11:4] == 0)) begin
         e_msi_v = 1; e_mdest = a[63:32] | {24'h0, a[19:12]}; e_mdm = a[2];
         e_mvec = wd[7:0]; e_mdlv = wd[10:8]; e_mtrig = wd[15];
      end else begin
         predict(is_mm, we, is_mm ? a[11:4] : a[7:0], wd);
      end
      @(negedge clk);
      mm_req = 0; xr_req = 0;
      @(posedge clk); #1;
      e_rsp_v = 0; e_msi_v = 0;
      if (ipi_ready) e_ipi_v = 0;
   endtask

   task automatic mmw(input string t, input logic [7:0] ix, input logic [31:0] d);
      acc(t, 1, 1, {52'h0, ix, 4'h0}, 4'd4, {32'h0, d});
   endtask
   task automatic mmr(input string t, input logic [7:0] ix);
      acc(t, 1, 0, {52'h0, ix, 4'h0}, 4'd4, 64'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      @(posedge clk); #1; run_chk = 1;
      // R6 R7 reset values, legacy mode
      mmr("R6 id reset", 8'h02);
      mmr("R6 ldr reset", 8'h0D);
      mmr("R7 dfr reset", 8'h0E);
      mmw("R6 ldr write", 8'h0D, 32'hA500_0000);
      mmr("R6 ldr read", 8'h0D);
      mmw("R7 dfr write", 8'h0E, 32'h0ABC_DEF0);
      mmr("R7 dfr read", 8'h0E);
      mmw("R6 id write", 8'h02, 32'h7700_0000);
      mmr("R6 id read", 8'h02);
      // R1 R2 legacy command
      mmw("R2 hi write", 8'h31, 32'h3C00_0000);
      mmr("R2 hi read", 8'h31);
      mmw("R1 cmd pattern a", 8'h30, 32'h0008_8D21);
      mmr("R1 lo read", 8'h30);
      mmw("R1 cmd pattern b", 8'h30, 32'h000C_0032);
      // R5 legacy self-IPI refused
      mmw("R5 self legacy", 8'h3F, 32'h0000_0055);
      // R8 extended port in legacy mode
      acc("R8 xr read legacy", 0, 0, 64'h02, 4'd8, 64'h0);
      acc("R8 xr write legacy", 0, 1, 64'h30, 4'd8, 64'h0000_0001_0000_0011);
      mmr("R8 lo unchanged", 8'h30);
      // R10 narrow
      acc("R10 narrow write", 1, 1, 64'h20, 4'd2, 64'h1100_0000);
      acc("R10 narrow read", 1, 0, 64'h20, 4'd1, 64'h0);
      mmr("R10 id unchanged", 8'h02);
      // R11 message diversion
      acc("R11 msi high addr", 1, 1, 64'h0000_1200_FEE4_5004, 4'd4, 64'h8312);
      acc("R11 msi index0", 1, 1, 64'h0000_0000_0000_0004, 4'd4, 64'h0041);
      // R9 undefined index and self read
      mmr("R9 undefined read", 8'h08);
      mmr("R9 self read", 8'h3F);
      // extended mode
      @(negedge clk); ext_mode = 1;
      acc("R6 ext id", 0, 0, 64'h02, 4'd8, 64'h0);
      acc("R6 ext ldr", 0, 0, 64'h0D, 4'd8, 64'h0);
      acc("R7 ext dfr", 0, 0, 64'h0E, 4'd8, 64'h0);
      acc("R4 ext id write", 0, 1, 64'h02, 4'd8, 64'h0000_0000_1100_0000);
      acc("R4 ext ldr write", 0, 1, 64'h0D, 4'd8, 64'h0000_0000_2200_0000);
      acc("R4 ext dfr write", 0, 1, 64'h0E, 4'd8, 64'h0000_0000_0000_0000);
      acc("R4 ext hi write", 0, 1, 64'h31, 4'd8, 64'h0000_0000_9900_0000);
      acc("R3 ext cmd", 0, 1, 64'h30, 4'd8, 64'hABCD_0001_0004_00F0);
      acc("R3 ext hi read", 0, 0, 64'h31, 4'd8, 64'h0);
      acc("R5 ext self", 0, 1, 64'h3F, 4'd8, 64'h0000_0000_0000_01AB);
      mmw("R5 mm self ext", 8'h3F, 32'h0000_0066);
      // R12 hold and block
      @(negedge clk); ipi_ready = 0;
      acc("R12 held cmd", 0, 1, 64'h30, 4'd8, 64'h0000_0007_0000_0399);
      repeat (3) @(posedge clk);
      @(negedge clk);
      tag = "R12 blocked";
      mm_req = 1; mm_we = 1; mm_addr = 64'h020; mm_size = 4; mm_wdata = 32'h5500_0000;
      xr_req = 1; xr_we = 1; xr_idx = 8'h3F; xr_wdata = 64'h1;
      @(posedge clk); #1;
      @(negedge clk); mm_req = 0; xr_req = 0; ipi_ready = 1;
      @(posedge clk); #1; e_ipi_v = 0;
      // R12 both ports: extended request ignored
      @(negedge clk);
      tag = "R12 both ports";
      mm_req = 1; mm_we = 0; mm_addr = 64'h310; mm_size = 4;
      xr_req = 1; xr_we = 1; xr_idx = 8'h3F; xr_wdata = 64'h77;
      @(posedge clk); #1;
      e_rsp_v = 1; e_err = 0; e_data = {32'h0, m_hi};
      @(negedge clk); mm_req = 0; xr_req = 0;
      @(posedge clk); #1; e_rsp_v = 0;
      // R4 back in legacy: locked writes left state untouched
      @(negedge clk); ext_mode = 0;
      mmr("R4 id kept", 8'h02);
      mmr("R4 ldr kept", 8'h0D);
      mmr("R3 hi kept", 8'h31);
      repeat (2) @(posedge clk);
      @(negedge clk); run_chk = 0;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule